// File: doc/BRIEF.md
# Byte-to-Word Bus Bridge

This block lets a host with an 8-bit data bus exchange 16-bit words with a peripheral that has a 16-bit data bus, such as a parallel disk interface. Every word moves in two host cycles, and each cycle is marked by one of four active-low strobes: write-low, write-high, read-low and read-high. For writes, the low byte is parked in a staging register, and the high byte flows straight through while the write-high strobe is active. For reads, the low byte flows straight through, and the high byte is parked in a separate staging register that the read-high cycle returns to the host.

The strobes are asynchronous to the system clock. A chain of flops synchronizes them before use. A staging register loads on the synchronized release, which is the rising edge, of its strobe. Each bus side is driven as a data vector plus an output enable, so the chip top can build its tri-state pads. If two or more strobes overlap, every output enable is forced off and a one-cycle conflict pulse is raised.

Top module: `byte_word_bridge`

## Requirements
- R1: After reset, both staging registers hold zero, host_oe_o and per_oe_o are low, and conflict_o is low.
- R2: When wr_lo_n_i is released (0 to 1), host_d_i is loaded into the write staging register. The register can be observed on per_d_o[7:0] during a later write-high cycle.
- R3: While only wr_hi_n_i is asserted (synchronized), per_oe_o is high, per_d_o[15:8] equals host_d_i, and per_d_o[7:0] equals the write staging register.
- R4: While only rd_lo_n_i is asserted, host_oe_o is high and host_d_o equals per_d_i[7:0].
- R5: When rd_lo_n_i is released, per_d_i[15:8] is loaded into the read staging register.
- R6: While only rd_hi_n_i is asserted, host_oe_o is high, per_oe_o is low, and host_d_o equals the read staging register rather than per_d_i.
- R7: A staging register changes only on the release of its own strobe. Data that changes after the release has no effect on it.
- R8: While more than one strobe is asserted, host_oe_o and per_oe_o are both low.
- R9: On entry into an overlap of strobes, conflict_o is high for exactly one clock cycle.
- R10: A strobe acts only after SYNC_STAGES rising clock edges. One edge after a strobe falls, the output enables are still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_n_i | input | 1 | Write-low strobe, active low |
| wr_hi_n_i | input | 1 | Write-high strobe, active low |
| rd_lo_n_i | input | 1 | Read-low strobe, active low |
| rd_hi_n_i | input | 1 | Read-high strobe, active low |
| host_d_i | input | BYTE_W | Host bus data in |
| host_d_o | output | BYTE_W | Host bus data out |
| host_oe_o | output | 1 | Host bus output enable |
| per_d_i | input | 2*BYTE_W | Peripheral bus data in |
| per_d_o | output | 2*BYTE_W | Peripheral bus data out |
| per_oe_o | output | 1 | Peripheral bus output enable |
| conflict_o | output | 1 | One-cycle pulse on strobe overlap |

## Verification
The bench builds the bridge with its defaults: BYTE_W of 8 and SYNC_STAGES of 2. With these values the synchronizer latency is short enough that the bench can check the exact edge at which an enable rises. Byte patterns with distinct upper and lower halves show whether a byte has been swapped or taken from the wrong lane. Both staging registers are read back only through the bridge's own upper cycles.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int NUM_STB = 4;
  // strobe lane order inside the synchronized vector
  localparam int STB_WR_LO = 0;
  localparam int STB_WR_HI = 1;
  localparam int STB_RD_LO = 2;
  localparam int STB_RD_HI = 3;
endpackage

// File: rtl/bwb_strobe_sync.sv
module bwb_strobe_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stb_n_i,
  output logic [N-1:0] act_o,
  output logic [N-1:0] rel_o
);
  logic [N-1:0] last_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], stb_n_i[g]};
    end
    assign act_o[g] = ~chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= act_o;
  end

  // release = was active, now inactive
  assign rel_o = last_q & ~act_o;
endmodule

// File: rtl/bwb_stage_reg.sv
module bwb_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/bwb_oe_ctrl.sv
module bwb_oe_ctrl
  import bwb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_STB-1:0] act_i,
  output logic               overlap_o,
  output logic               host_oe_o,
  output logic               per_oe_o,
  output logic               conflict_o
);
  logic overlap_q;

  // more than one bit set
  assign overlap_o  = |(act_i & (act_i - NUM_STB'(1)));
  assign per_oe_o   = act_i[STB_WR_HI] & ~overlap_o;
  assign host_oe_o  = (act_i[STB_RD_LO] | act_i[STB_RD_HI]) & ~overlap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overlap_q  <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      overlap_q  <= overlap_o;
      conflict_o <= overlap_o & ~overlap_q;
    end
  end
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
  import bwb_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_n_i,
  input  logic                wr_hi_n_i,
  input  logic                rd_lo_n_i,
  input  logic                rd_hi_n_i,
  input  logic [BYTE_W-1:0]   host_d_i,
  output logic [BYTE_W-1:0]   host_d_o,
  output logic                host_oe_o,
  input  logic [2*BYTE_W-1:0] per_d_i,
  output logic [2*BYTE_W-1:0] per_d_o,
  output logic                per_oe_o,
  output logic                conflict_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [NUM_STB-1:0] stb_n, act, rel;
  logic [BYTE_W-1:0]  wr_lo_q, rd_hi_q;
  logic               overlap;

  assign stb_n[STB_WR_LO] = wr_lo_n_i;
  assign stb_n[STB_WR_HI] = wr_hi_n_i;
  assign stb_n[STB_RD_LO] = rd_lo_n_i;
  assign stb_n[STB_RD_HI] = rd_hi_n_i;

  bwb_strobe_sync #(.N(NUM_STB), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .stb_n_i(stb_n), .act_o(act), .rel_o(rel)
  );

  bwb_stage_reg #(.W(BYTE_W)) u_wr_lo (
    .clk_i, .rst_ni, .load_i(rel[STB_WR_LO]), .d_i(host_d_i), .q_o(wr_lo_q)
  );

  bwb_stage_reg #(.W(BYTE_W)) u_rd_hi (
    .clk_i, .rst_ni, .load_i(rel[STB_RD_LO]), .d_i(per_d_i[WORD_W-1:BYTE_W]),
    .q_o(rd_hi_q)
  );

  bwb_oe_ctrl u_oe (
    .clk_i, .rst_ni, .act_i(act), .overlap_o(overlap),
    .host_oe_o, .per_oe_o, .conflict_o
  );

  assign per_d_o  = {host_d_i, wr_lo_q};
  assign host_d_o = act[STB_RD_HI] ? rd_hi_q : per_d_i[BYTE_W-1:0];
endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] host_d_i,
  input logic              host_oe_o,
  input logic [2*BYTE_W-1:0] per_d_o,
  input logic              per_oe_o,
  input logic              conflict_o,
  input logic              wr_load,
  input logic [BYTE_W-1:0] wr_lo_q
);
  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!host_oe_o && !per_oe_o); // R1
  end

  AST_OE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_oe_o && per_oe_o)); // R8

  AST_PER_HIGH_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_oe_o |-> per_d_o[2*BYTE_W-1:BYTE_W] == host_d_i); // R3

  AST_CONFLICT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> !conflict_o); // R9

  AST_WR_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_load |=> $stable(wr_lo_q)); // R7
endmodule

bind byte_word_bridge bwb_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_d_i(host_d_i), .host_oe_o(host_oe_o),
  .per_d_o(per_d_o), .per_oe_o(per_oe_o), .conflict_o(conflict_o),
  .wr_load(rel[0]), .wr_lo_q(wr_lo_q)
);

// File: tb/sim_byte_word_bridge.sv
`timescale 1ns/1ps
module sim_byte_word_bridge;
  localparam int BW = 8;
  localparam int SS = 2;

  logic clk = 0, rst_n = 0;
  logic wl = 1, wh = 1, rl = 1, rh = 1;
  logic [BW-1:0]   hd_i = '0;
  logic [2*BW-1:0] pd_i = '0;
  logic [BW-1:0]   hd_o;
  logic [2*BW-1:0] pd_o;
  logic h_oe, p_oe, conf;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  byte_word_bridge #(.BYTE_W(BW), .SYNC_STAGES(SS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_n_i(wl), .wr_hi_n_i(wh),
    .rd_lo_n_i(rl), .rd_hi_n_i(rh), .host_d_i(hd_i), .host_d_o(hd_o),
    .host_oe_o(h_oe), .per_d_i(pd_i), .per_d_o(pd_o), .per_oe_o(p_oe),
    .conflict_o(conf)
  );

  always @(negedge clk) if (conf) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [BW-1:0] lo, logic [BW-1:0] hi, logic [2*BW-1:0] expect_pd);
    hd_i = lo; wl = 0; wait_n(4); wl = 1; wait_n(4);
    hd_i = hi; wh = 0; wait_n(4);
    chk("R3 per_oe", p_oe, 1);
    chk("R3 per_d", pd_o, expect_pd);
    wh = 1; wait_n(4);
  endtask

  task automatic t_reset;
    chk("R1 host_oe", h_oe, 0);
    chk("R1 per_oe", p_oe, 0);
    chk("R1 conflict", conf, 0);
    rh = 0; wait_n(4); chk("R1 rd reg zero", hd_o, 0); rh = 1; wait_n(4);
    hd_i = 8'h5A; wh = 0; wait_n(4); chk("R1 wr reg zero", pd_o[7:0], 0); wh = 1; wait_n(4);
  endtask

  task automatic t_write;
    write_word(8'h34, 8'h12, 16'h1234);   // R2
    write_word(8'hC3, 8'hA5, 16'hA5C3);   // R2
  endtask

  task automatic t_read;
    pd_i = 16'hBEEF; rl = 0; wait_n(4);
    chk("R4 host_oe", h_oe, 1);
    chk("R4 host_d", hd_o, 8'hEF);
    chk("R4 per_oe off", p_oe, 0);
    rl = 1; wait_n(4);
    pd_i = 16'h0000; rh = 0; wait_n(4);
    chk("R6 host_oe", h_oe, 1);
    chk("R6 per_oe off", p_oe, 0);
    chk("R5 R6 staged high", hd_o, 8'hBE);
    rh = 1; wait_n(4);
  endtask

  task automatic t_hold;
    hd_i = 8'h77; wl = 0; wait_n(4); wl = 1; wait_n(4);
    hd_i = 8'h99; wait_n(6);              // change after release: R7
    wh = 0; wait_n(4); chk("R7 wr hold", pd_o[7:0], 8'h77); wh = 1; wait_n(4);
    pd_i = 16'h6611; rl = 0; wait_n(4); rl = 1; wait_n(4);
    pd_i = 16'h2222; wait_n(6);
    rh = 0; wait_n(4); chk("R7 rd hold", hd_o, 8'h66); rh = 1; wait_n(4);
  endtask

  task automatic t_conflict;
    pulses = 0;
    wh = 0; rl = 0; wait_n(6);
    chk("R8 host_oe off", h_oe, 0);
    chk("R8 per_oe off", p_oe, 0);
    wh = 1; rl = 1; wait_n(6);
    chk("R9 one pulse", pulses, 1);
    pulses = 0;
    rh = 0; rl = 0; wait_n(3);
    chk("R8 two reads", h_oe, 0);
    rh = 1; rl = 1; wait_n(5);
    chk("R9 second pulse", pulses, 1);
  endtask

  task automatic t_latency;
    rl = 0;
    wait_n(1); chk("R10 not yet", h_oe, 0);
    wait_n(SS - 1); chk("R10 enabled", h_oe, 1);
    rl = 1; wait_n(4);
  endtask

  initial begin
    wait_n(3); rst_n = 1; wait_n(2);
    t_reset;
    t_write;
    t_read;
    t_hold;
    t_conflict;
    t_latency;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule